// File: doc/BRIEF.md
# Cross-Domain Palette Lookup Table

This block is the colour palette stage of a display pixel pipeline. Software fills the palette through a single write-only register on the bus clock. Every 32-bit write carries both the palette slot and the 24-bit colour for it. The pair crosses into the pixel clock domain as one bundle, using a toggle request and acknowledge handshake. On the pixel side, each valid pixel presents an index. One pixel clock later the block returns the RGB888 colour stored at that index, together with a delayed valid flag.

A compact mode serves 4-bit pixel formats. In this mode, only the low nibble of an index counts, and it is repeated into both halves of the palette address. This applies to the palette slot of a write as well as to the pixel index of a lookup. The bus side shows a busy flag while a write is still in flight. A second write that arrives during that time is parked in a one-deep slot and forwarded once the first has been acknowledged.

Top module: `pal_cdc_lut`

## Requirements
- R1: While rst_ni is low and directly after it rises, busy_o, pix_valid_o and pix_rgb_o are all zero.
- R2: A bus write places wr_data_i[23:0] into the single palette slot selected by wr_data_i[31:24]. Red is bits 23:16, green is bits 15:8 and blue is bits 7:0. No other slot changes, and slots may be filled in any order.
- R3: pix_valid_o equals pix_valid_i of the previous pixel clock. When it is high, pix_rgb_o holds the palette content at the index sampled on that previous edge.
- R4: busy_o is high on the first bus clock after a write is sampled. It stays high until that write, and any write parked behind it, has been acknowledged from the pixel side, which takes well under 20 bus clocks.
- R5: A write sampled while busy_o is high is kept and applied after the earlier one. Two writes on consecutive bus clocks both land, and for a repeated slot the later colour is the one kept.
- R6: With nibble_mode_i high, a write to slot n lands at address {n[3:0],n[3:0]}, which is n*17 for n below 16. A lookup of pixel value p reads address {p[3:0],p[3:0]}, and bits 7:4 of p are ignored.
- R7: When a palette write and a lookup hit the same address on the same pixel clock, the lookup returns the colour held before that write. Lookups of that address then move once from the old colour to the new one and never back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk_i | input | 1 | Bus register clock |
| pix_clk_i | input | 1 | Pixel clock; palette memory and lookup path |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| nibble_mode_i | input | 1 | 1: 4-bit index mode, 0: 8-bit index mode; quasi-static |
| wr_en_i | input | 1 | Write strobe for the palette register |
| wr_data_i | input | 32 | [31:24] palette slot, [23:0] RGB888 colour |
| busy_o | output | 1 | A palette write is still crossing or parked |
| pix_valid_i | input | 1 | Pixel index valid |
| pix_idx_i | input | 8 | Pixel palette index |
| pix_valid_o | output | 1 | pix_valid_i delayed by one pixel clock |
| pix_rgb_o | output | 24 | Looked-up colour, red in 23:16 |

## Verification
The assertions assume that software never writes while the parked slot is full and a crossing is also still open. The stimulus respects this by waiting for busy_o to fall before each write, and it only issues two writes back to back when busy_o is low. nibble_mode_i is assumed to change only while the block is idle with no lookups running, and the bench switches it only at such points. The read-before-write property is exercised by holding a lookup on one address across every pixel clock while a write to that same address crosses over.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int PAL_AW    = 8;
  localparam int CH_W      = 8;
  localparam int RGB_W     = 3 * CH_W;
  localparam int REG_W     = PAL_AW + RGB_W;
  localparam int PAL_DEPTH = 1 << PAL_AW;
  localparam int NIB_W     = PAL_AW / 2;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;

  typedef struct packed {
    logic [PAL_AW-1:0] addr;
    rgb_t              rgb;
  } wr_bundle_t;
endpackage

// File: rtl/pal_sync.sv
module pal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] s_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= {s_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = s_q[STAGES-1];
endmodule

// File: rtl/pal_idx_map.sv
// Replicates the low nibble across the address in compact mode.
module pal_idx_map #(
  parameter int AW = 8,
  parameter int NW = 4
) (
  input  logic          nibble_mode_i,
  input  logic [AW-1:0] idx_i,
  output logic [AW-1:0] addr_o
);
  localparam int REPS = AW / NW;

  for (genvar g = 0; g < REPS; g++) begin : g_rep
    assign addr_o[g*NW +: NW] = nibble_mode_i ? idx_i[NW-1:0] : idx_i[g*NW +: NW];
  end
endmodule

// File: rtl/pal_bus_side.sv
module pal_bus_side
  import pal_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nibble_mode_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             ack_tgl_i,
  output wr_bundle_t       bundle_o,
  output logic             req_tgl_o,
  output logic             inflight_o,
  output logic             pend_v_o,
  output logic             busy_o
);
  logic [PAL_AW-1:0] slot;
  wr_bundle_t        new_b;
  wr_bundle_t        hold_q;
  wr_bundle_t        pend_q;
  logic              pend_v_q;
  logic              req_q;
  logic              ack_s;
  logic              inflight;

  pal_idx_map #(.AW(PAL_AW), .NW(NIB_W)) u_map (
    .nibble_mode_i (nibble_mode_i),
    .idx_i         (wr_data_i[REG_W-1 -: PAL_AW]),
    .addr_o        (slot)
  );

  pal_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ack_tgl_i),
    .q_o    (ack_s)
  );

  assign new_b.addr = slot;
  assign new_b.rgb  = rgb_t'(wr_data_i[RGB_W-1:0]);
  assign inflight   = req_q ^ ack_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      req_q    <= 1'b0;
    end else if (!inflight) begin
      if (pend_v_q) begin
        // parked write launches; a fresh write refills the slot
        hold_q <= pend_q;
        req_q  <= ~req_q;
        if (wr_en_i) pend_q <= new_b;
        else         pend_v_q <= 1'b0;
      end else if (wr_en_i) begin
        hold_q <= new_b;
        req_q  <= ~req_q;
      end
    end else if (wr_en_i) begin
      pend_q   <= new_b;
      pend_v_q <= 1'b1;
    end
  end

  assign bundle_o   = hold_q;
  assign req_tgl_o  = req_q;
  assign inflight_o = inflight;
  assign pend_v_o   = pend_v_q;
  assign busy_o     = inflight | pend_v_q;
endmodule

// File: rtl/pal_pix_capture.sv
module pal_pix_capture
  import pal_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_tgl_i,
  input  wr_bundle_t        bundle_i,
  output logic              we_o,
  output logic [PAL_AW-1:0] waddr_o,
  output rgb_t              wdata_o,
  output logic              ack_tgl_o
);
  logic req_s;
  logic seen_q;

  pal_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (req_tgl_i),
    .q_o    (req_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= req_s;
  end

  // bundle is held stable on the bus side until the ack returns
  assign we_o      = req_s ^ seen_q;
  assign waddr_o   = bundle_i.addr;
  assign wdata_o   = bundle_i.rgb;
  assign ack_tgl_o = seen_q;
endmodule

// File: rtl/pal_lut_ram.sv
module pal_lut_ram
  import pal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PAL_AW-1:0] waddr_i,
  input  rgb_t              wdata_i,
  input  logic              rvalid_i,
  input  logic [PAL_AW-1:0] raddr_i,
  output logic              rvalid_o,
  output rgb_t              rdata_o
);
  rgb_t mem [PAL_DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // read sees the pre-write content on an address collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rvalid_i;
      rdata_o  <= mem[raddr_i];
    end
  end
endmodule

// File: rtl/pal_cdc_lut.sv
module pal_cdc_lut
  import pal_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              bus_clk_i,
  input  logic              pix_clk_i,
  input  logic              rst_ni,
  input  logic              nibble_mode_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic              busy_o,
  input  logic              pix_valid_i,
  input  logic [PAL_AW-1:0] pix_idx_i,
  output logic              pix_valid_o,
  output logic [RGB_W-1:0]  pix_rgb_o
);
  wr_bundle_t        bus_bundle;
  logic              req_tgl;
  logic              ack_tgl;
  logic              bus_inflight;
  logic              bus_pend_v;
  logic              ram_we;
  logic [PAL_AW-1:0] ram_waddr;
  rgb_t              ram_wdata;
  logic [PAL_AW-1:0] ram_raddr;
  rgb_t              ram_rdata;

  pal_bus_side #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
    .clk_i         (bus_clk_i),
    .rst_ni        (rst_ni),
    .nibble_mode_i (nibble_mode_i),
    .wr_en_i       (wr_en_i),
    .wr_data_i     (wr_data_i),
    .ack_tgl_i     (ack_tgl),
    .bundle_o      (bus_bundle),
    .req_tgl_o     (req_tgl),
    .inflight_o    (bus_inflight),
    .pend_v_o      (bus_pend_v),
    .busy_o        (busy_o)
  );

  pal_pix_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk_i     (pix_clk_i),
    .rst_ni    (rst_ni),
    .req_tgl_i (req_tgl),
    .bundle_i  (bus_bundle),
    .we_o      (ram_we),
    .waddr_o   (ram_waddr),
    .wdata_o   (ram_wdata),
    .ack_tgl_o (ack_tgl)
  );

  pal_idx_map #(.AW(PAL_AW), .NW(NIB_W)) u_rmap (
    .nibble_mode_i (nibble_mode_i),
    .idx_i         (pix_idx_i),
    .addr_o        (ram_raddr)
  );

  pal_lut_ram u_ram (
    .clk_i    (pix_clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ram_we),
    .waddr_i  (ram_waddr),
    .wdata_i  (ram_wdata),
    .rvalid_i (pix_valid_i),
    .raddr_i  (ram_raddr),
    .rvalid_o (pix_valid_o),
    .rdata_o  (ram_rdata)
  );

  assign pix_rgb_o = ram_rdata;
endmodule

// File: rtl/pal_cdc_lut_chk.sv
module pal_cdc_lut_chk
  import pal_pkg::*;
(
  input logic              bus_clk_i,
  input logic              pix_clk_i,
  input logic              rst_ni,
  input logic              nibble_mode_i,
  input logic              wr_en_i,
  input logic              busy_o,
  input logic              pix_valid_i,
  input logic              pix_valid_o,
  input logic [RGB_W-1:0]  pix_rgb_o,
  input logic              bus_inflight,
  input logic              bus_pend_v,
  input wr_bundle_t        bus_bundle,
  input logic              ram_we,
  input logic [PAL_AW-1:0] ram_waddr,
  input logic [PAL_AW-1:0] ram_raddr
);
  a_r1_reset_quiet: assert property (@(posedge bus_clk_i) !rst_ni |-> !busy_o);

  a_r3_valid_high: assert property (@(posedge pix_clk_i) disable iff (!rst_ni)
    pix_valid_i |=> pix_valid_o);

  a_r3_valid_low: assert property (@(posedge pix_clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> !pix_valid_o);

  a_r4_busy_after_write: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    wr_en_i |=> busy_o);

  a_r4_bundle_stable: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    (bus_inflight && $past(bus_inflight)) |-> $stable(bus_bundle));

  // R5: input rule, no write while a crossing is open and the slot is full
  a_r5_no_overflow: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    (bus_inflight && bus_pend_v) |-> !wr_en_i);

  a_r6_nibble_addr: assert property (@(posedge pix_clk_i) disable iff (!rst_ni)
    (ram_we && nibble_mode_i) |-> (ram_waddr[PAL_AW-1:NIB_W] == ram_waddr[NIB_W-1:0]));

  a_r7_read_before_write: assert property (@(posedge pix_clk_i) disable iff (!rst_ni)
    (ram_we && ram_waddr == ram_raddr && $past(ram_raddr) == ram_raddr && !$past(ram_we))
    |=> (pix_rgb_o == $past(pix_rgb_o)));
endmodule

bind pal_cdc_lut pal_cdc_lut_chk u_chk (
  .bus_clk_i     (bus_clk_i),
  .pix_clk_i     (pix_clk_i),
  .rst_ni        (rst_ni),
  .nibble_mode_i (nibble_mode_i),
  .wr_en_i       (wr_en_i),
  .busy_o        (busy_o),
  .pix_valid_i   (pix_valid_i),
  .pix_valid_o   (pix_valid_o),
  .pix_rgb_o     (pix_rgb_o),
  .bus_inflight  (bus_inflight),
  .bus_pend_v    (bus_pend_v),
  .bus_bundle    (bus_bundle),
  .ram_we        (ram_we),
  .ram_waddr     (ram_waddr),
  .ram_raddr     (ram_raddr)
);

// File: tb/pal_cdc_lut_tb.sv
module pal_cdc_lut_tb_top;
  logic        bus_clk = 1'b0;
  logic        pix_clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        nibble_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        busy;
  logic        pix_valid_i = 1'b0;
  logic [7:0]  pix_idx = '0;
  logic        pix_valid_o;
  logic [23:0] pix_rgb;

  int checks = 0;
  int errors = 0;

  logic [23:0] pal   [256];
  logic [23:0] old_v [256];
  bit          known [256];
  bit          dirty [256];
  bit          seen_new [256];

  logic        exp_v;
  logic [7:0]  exp_a;

  always #5 bus_clk = ~bus_clk;
  always #7 pix_clk = ~pix_clk;

  pal_cdc_lut dut_i (
    .bus_clk_i     (bus_clk),
    .pix_clk_i     (pix_clk),
    .rst_ni        (rst_ni),
    .nibble_mode_i (nibble_mode),
    .wr_en_i       (wr_en),
    .wr_data_i     (wr_data),
    .busy_o        (busy),
    .pix_valid_i   (pix_valid_i),
    .pix_idx_i     (pix_idx),
    .pix_valid_o   (pix_valid_o),
    .pix_rgb_o     (pix_rgb)
  );

  function automatic logic [7:0] map_a(input logic [7:0] a, input logic m);
    return m ? {a[3:0], a[3:0]} : a;
  endfunction

  function automatic logic [23:0] colour(input int i);
    logic [7:0] v;
    v = 8'(i);
    return {v, ~v, v ^ 8'h5a};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference: expected lookup result one pixel clock later
  always @(posedge pix_clk) begin
    if (!rst_ni) exp_v <= 1'b0;
    else begin
      exp_v <= pix_valid_i;
      exp_a <= map_a(pix_idx, nibble_mode);
    end
  end

  always @(negedge pix_clk) begin
    if (rst_ni) begin
      chk(pix_valid_o === exp_v, "R3 valid delay", 32'(pix_valid_o), 32'(exp_v));
      if (exp_v && known[exp_a]) begin
        if (dirty[exp_a]) begin
          chk(pix_rgb === pal[exp_a] || pix_rgb === old_v[exp_a], "R7 old or new",
              32'(pix_rgb), 32'(pal[exp_a]));
          if (seen_new[exp_a] && pal[exp_a] != old_v[exp_a])
            chk(pix_rgb !== old_v[exp_a], "R7 no revert", 32'(pix_rgb), 32'(pal[exp_a]));
          if (pix_rgb === pal[exp_a]) seen_new[exp_a] = 1'b1;
        end else begin
          chk(pix_rgb === pal[exp_a], "R3 lookup colour", 32'(pix_rgb), 32'(pal[exp_a]));
        end
      end
    end
  end

  task automatic model_wr(input logic [7:0] a, input logic [23:0] c);
    logic [7:0] m;
    m = map_a(a, nibble_mode);
    if (!dirty[m]) old_v[m] = known[m] ? pal[m] : c;
    dirty[m] = 1'b1;
    pal[m]   = c;
    known[m] = 1'b1;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [23:0] c);
    @(negedge bus_clk);
    wr_en   = 1'b1;
    wr_data = {a, c};
    model_wr(a, c);
    @(negedge bus_clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy && n < 40) begin
      @(negedge bus_clk);
      n++;
    end
    if (tag != "") chk(n < 20, tag, 32'(n), 32'd20);
    for (int i = 0; i < 256; i++) begin
      dirty[i]    = 1'b0;
      seen_new[i] = 1'b0;
    end
  endtask

  task automatic pix_look(input logic [7:0] idx, input logic v);
    @(negedge pix_clk);
    pix_valid_i = v;
    pix_idx     = idx;
  endtask

  task automatic look_chk(input logic [7:0] idx, input logic [23:0] exp, input string tag);
    pix_look(idx, 1'b1);
    @(negedge pix_clk);
    chk(pix_valid_o === 1'b1 && pix_rgb === exp, tag, 32'(pix_rgb), 32'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge bus_clk);
    errors++;
    $display("FAIL R4 watchdog act=hung exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      known[i] = 1'b0; dirty[i] = 1'b0; seen_new[i] = 1'b0;
      pal[i] = '0; old_v[i] = '0;
    end
    repeat (4) @(negedge bus_clk);
    chk(busy === 1'b0, "R1 busy in reset", 32'(busy), 0);
    chk(pix_valid_o === 1'b0, "R1 valid in reset", 32'(pix_valid_o), 0);
    chk(pix_rgb === '0, "R1 rgb in reset", 32'(pix_rgb), 0);
    rst_ni = 1'b1;
    @(negedge bus_clk);
    chk(busy === 1'b0, "R1 busy after reset", 32'(busy), 0);

    // R4: busy right after the write, drops within bound
    bus_wr(8'hff, colour(255));
    chk(busy === 1'b1, "R4 busy after write", 32'(busy), 1);
    wait_idle("R4 busy clears");

    // R2: fill every slot in reverse order
    for (int i = 254; i >= 0; i--) begin
      bus_wr(8'(i), colour(i));
      wait_idle("");
    end
    for (int i = 0; i < 256; i++) pix_look(8'(i), (i % 3) != 0);
    for (int i = 255; i >= 0; i -= 7) pix_look(8'(i), 1'b1);
    pix_look(8'h00, 1'b0);
    look_chk(8'h7e, colour(8'h7e), "R2 slot 7e");
    look_chk(8'h00, colour(0), "R2 slot 00");
    pix_look(8'h00, 1'b0);

    // R5: back-to-back writes, second one parked
    @(negedge bus_clk);
    wr_en = 1'b1; wr_data = {8'h20, 24'h112233}; model_wr(8'h20, 24'h112233);
    @(negedge bus_clk);
    wr_data = {8'h21, 24'h445566}; model_wr(8'h21, 24'h445566);
    @(negedge bus_clk);
    wr_en = 1'b0;
    chk(busy === 1'b1, "R5 busy with parked write", 32'(busy), 1);
    wait_idle("R5 both drained");
    look_chk(8'h20, 24'h112233, "R5 first write");
    look_chk(8'h21, 24'h445566, "R5 second write");
    pix_look(8'h00, 1'b0);
    @(negedge bus_clk);
    wr_en = 1'b1; wr_data = {8'h30, 24'hcafe01}; model_wr(8'h30, 24'hcafe01);
    @(negedge bus_clk);
    wr_data = {8'h30, 24'hbeef02}; model_wr(8'h30, 24'hbeef02);
    @(negedge bus_clk);
    wr_en = 1'b0;
    wait_idle("R5 same slot drained");
    look_chk(8'h30, 24'hbeef02, "R5 later colour wins");
    look_chk(8'h31, colour(8'h31), "R2 neighbour untouched");

    // R7: lookup held on a slot while it is rewritten
    fork
      begin
        for (int k = 0; k < 40; k++) pix_look(8'h40, 1'b1);
      end
      begin
        bus_wr(8'h40, 24'h0a0b0c);
        wait_idle("R7 write done");
      end
    join
    look_chk(8'h40, 24'h0a0b0c, "R7 new colour settled");
    pix_look(8'h00, 1'b0);

    // R6: compact index mode
    @(negedge bus_clk);
    nibble_mode = 1'b1;
    bus_wr(8'h03, 24'h123456);
    wait_idle("R6 write a");
    bus_wr(8'hfc, 24'h654321);
    wait_idle("R6 write b");
    look_chk(8'h03, 24'h123456, "R6 lookup 03");
    look_chk(8'he3, 24'h123456, "R6 upper nibble ignored");
    look_chk(8'h0c, 24'h654321, "R6 lookup 0c");
    pix_look(8'h00, 1'b0);
    @(negedge pix_clk);
    nibble_mode = 1'b0;
    look_chk(8'h33, 24'h123456, "R6 stored at 0x33");
    look_chk(8'hcc, 24'h654321, "R6 stored at 0xcc");
    look_chk(8'h03, colour(8'h03), "R6 slot 03 untouched");
    look_chk(8'hfc, colour(8'hfc), "R6 slot fc untouched");
    pix_look(8'h00, 1'b0);
    repeat (4) @(negedge pix_clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule